// File: doc/BRIEF.md
# Async PPP Octet Escape Encoder

This block is the transmit-side byte processor for character-oriented PPP over an asynchronous line. Payload bytes arrive on a valid/ready stream, and `in_last` marks the final byte of a frame. The block emits a frame as a byte stream: an opening flag, the payload, a frame check sequence and a closing flag. Any payload or check byte that the configured escape set selects is replaced by a two-byte escape pair. The output feeds a start/stop-bit character serializer, which lies outside this block.

The escape set has three parts. A 32-bit map selects control bytes 0x00 to 0x1F. A small number of programmable extra byte values can each be switched on separately. The flag and escape codes are always in the set. The check sequence is either the 16-bit CCITT FCS or the 32-bit CRC. It is chosen per frame.

Top module: `ppp_async_escaper`

## Requirements
- R1: During and after reset, with `in_valid` low, `out_valid` and `in_ready` are low.
- R2: When a frame starts (`in_valid` high while idle), the first output byte is the flag 0x7E, and `in_ready` stays low until that flag has been taken.
- R3: A payload byte b with b <= 0x1F is escaped exactly when bit b of `cfg_accm` is 1.
- R4: Payload bytes 0x7D and 0x7E are always escaped, whatever the configuration.
- R5: Extra character i is the value `cfg_extra[8*i+7:8*i]`. It causes escaping only while `cfg_extra_en[i]` is 1. A disabled entry has no effect on the output.
- R6: An escaped byte b is output as 0x7D followed by b XOR 0x20. `in_ready` is low while the second byte of the pair is offered.
- R7: A byte that no escape rule selects is passed through unchanged, in order.
- R8: With `cfg_crc32` = 0, the frame carries the 16-bit FCS: reflected polynomial 0x8408, preset 0xFFFF, computed over the unescaped payload, complemented, low byte first.
- R9: With `cfg_crc32` = 1, the frame carries the 32-bit CRC: reflected polynomial 0xEDB88320, preset 0xFFFFFFFF, complemented, least significant byte first. The mode is sampled when the opening flag is taken, and later changes do not affect that frame.
- R10: Check bytes pass through the same escape rules as payload bytes.
- R11: The byte accepted with `in_last` high is followed by the check bytes, then one closing flag 0x7E, and then the block returns to idle.
- R12: While `out_ready` is low, an offered output byte is held stable and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_accm | input | 32 | Escape map for bytes 0x00 to 0x1F (bit index = byte value) |
| cfg_extra | input | 8*N_EXTRA | Extra escape characters, entry i in bits 8i+7:8i |
| cfg_extra_en | input | N_EXTRA | Enable for each extra character |
| cfg_crc32 | input | 1 | 1 selects 32-bit CRC, 0 selects 16-bit FCS |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the last payload byte of a frame |
| in_ready | output | 1 | Payload byte accepted when high with in_valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Encoded output byte |
| out_ready | input | 1 | Downstream takes the output byte |

## Verification
A pending-escape flag left stuck, or a bad escape byte, shows up on the very next output byte. It either drops or repeats the XOR-ed byte, or corrupts the 0x7D that starts the pair. A CRC register that updates on the wrong cycle, or a mode latched at the wrong time, stays hidden until the end of the frame. It then appears as wrong check bytes, or as two bytes too many or too few before the closing flag. A state machine that slips a state shows at once as a missing or extra 0x7E flag, or as `in_ready` high at the wrong moment.

// File: rtl/ppp_async_escaper.sv
module ppp_async_escaper #(
  parameter int N_EXTRA = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          cfg_accm,
  input  logic [8*N_EXTRA-1:0] cfg_extra,
  input  logic [N_EXTRA-1:0]   cfg_extra_en,
  input  logic                 cfg_crc32,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  input  logic                 in_last,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [7:0]           out_data,
  input  logic                 out_ready
);
  localparam logic [1:0] S_IDLE = 2'd0, S_DATA = 2'd1, S_CRC = 2'd2, S_CLOSE = 2'd3;
  localparam logic [7:0] FLAG = 8'h7E, ESC = 8'h7D;

  logic [1:0]  st_q, cnt_q;
  logic        esc_pend, mode_q, need_esc, take;
  logic [7:0]  esc_byte, src, crc_byte;
  logic [31:0] crc_q, crc_tx;
  logic [N_EXTRA-1:0] xhit;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d, input logic m32);
    logic [31:0] r;
    logic fb;
    r = m32 ? c : {16'h0, c[15:0]};
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ (m32 ? 32'hEDB88320 : 32'h00008408);
    end
    return r;
  endfunction

  assign crc_tx   = ~crc_q;
  assign crc_byte = 8'(crc_tx >> {cnt_q, 3'b000});
  assign src      = (st_q == S_DATA) ? in_data : (st_q == S_CRC) ? crc_byte : FLAG;

  for (genvar i = 0; i < N_EXTRA; i++) begin : g_extra
    assign xhit[i] = cfg_extra_en[i] && (src == cfg_extra[8*i +: 8]);
  end

  assign need_esc = (st_q == S_DATA || st_q == S_CRC) &&
                    (src == FLAG || src == ESC || (src[7:5] == 3'b000 && cfg_accm[src[4:0]]) || |xhit);

  assign out_valid = esc_pend || st_q[1] || in_valid;
  assign out_data  = esc_pend ? esc_byte : need_esc ? ESC : src;
  assign take      = out_valid && out_ready && !esc_pend;
  assign in_ready  = (st_q == S_DATA) && !esc_pend && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= 2'd0;
      esc_pend <= 1'b0;
      esc_byte <= 8'h00;
      crc_q    <= '1;
      mode_q   <= 1'b0;
    end else begin
      if (esc_pend && out_ready) esc_pend <= 1'b0;
      if (take) begin
        if (need_esc) begin
          esc_pend <= 1'b1;
          esc_byte <= src ^ 8'h20;
        end
        case (st_q)
          S_IDLE: begin
            st_q   <= S_DATA;
            mode_q <= cfg_crc32;
            crc_q  <= '1;
          end
          S_DATA: begin
            crc_q <= crc_step(crc_q, in_data, mode_q);
            if (in_last) begin
              st_q  <= S_CRC;
              cnt_q <= 2'd0;
            end
          end
          S_CRC: begin
            if (cnt_q == (mode_q ? 2'd3 : 2'd1)) st_q <= S_CLOSE;
            else cnt_q <= cnt_q + 2'd1;
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module ppp_async_escaper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       esc_pend,
  input logic [1:0] st
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !in_valid) |-> (!out_valid && !in_ready));

  assert_raw_flag_place_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !esc_pend && out_data == 8'h7E) |-> (st == 2'd0 || st == 2'd3));

  assert_pair_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !esc_pend && out_data == 8'h7D) |=> (esc_pend && out_valid && !in_ready));

  assert_consume_emits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (out_valid && out_ready));

  assert_close_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && !esc_pend && out_valid && out_ready) |=> (st == 2'd0));

  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && (esc_pend || st[1])) |=> (out_valid && $stable(out_data)));
endmodule

bind ppp_async_escaper ppp_async_escaper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .esc_pend(esc_pend), .st(st_q)
);

// File: tb/sim_ppp_async_escaper.sv
module sim_ppp_async_escaper;
  logic        clk = 0, rst_n = 0;
  logic [31:0] cfg_accm = 0;
  logic [31:0] cfg_extra = 0;
  logic [3:0]  cfg_extra_en = 0;
  logic        cfg_crc32 = 0;
  logic        in_valid = 0, in_last = 0, out_ready = 0;
  logic [7:0]  in_data = 0;
  logic        in_ready, out_valid;
  logic [7:0]  out_data;

  int vectors = 0, miscompares = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         bp_on = 0;

  always #10 clk = ~clk;

  ppp_async_escaper #(.N_EXTRA(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_accm(cfg_accm), .cfg_extra(cfg_extra),
    .cfg_extra_en(cfg_extra_en), .cfg_crc32(cfg_crc32), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string esc_reason(logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) return "R4";
    if (b < 8'h20 && cfg_accm[b[4:0]]) return "R3";
    for (int i = 0; i < 4; i++)
      if (cfg_extra_en[i] && cfg_extra[8*i +: 8] == b) return "R5";
    return "";
  endfunction

  function automatic string plain_tag(logic [7:0] b);
    for (int i = 0; i < 4; i++)
      if (!cfg_extra_en[i] && cfg_extra[8*i +: 8] == b) return "R5";
    return (b < 8'h20) ? "R3" : "R7";
  endfunction

  function automatic void push_enc(logic [7:0] b, string crc_tag);
    string r;
    r = esc_reason(b);
    if (r != "") begin
      exp_q.push_back(8'h7D); tag_q.push_back(crc_tag != "" ? "R10" : r);
      exp_q.push_back(b ^ 8'h20); tag_q.push_back("R6");
    end else begin
      exp_q.push_back(b); tag_q.push_back(crc_tag != "" ? crc_tag : plain_tag(b));
    end
  endfunction

  function automatic logic [31:0] ref_fcs(logic [7:0] d[$], bit m32);
    logic [31:0] c32 = 32'hFFFFFFFF;
    logic [15:0] c16 = 16'hFFFF;
    foreach (d[k])
      for (int j = 0; j < 8; j++) begin
        if (m32) c32 = (c32[0] ^ d[k][j]) ? ((c32 >> 1) ^ 32'hEDB88320) : (c32 >> 1);
        else     c16 = (c16[0] ^ d[k][j]) ? ((c16 >> 1) ^ 16'h8408) : (c16 >> 1);
      end
    return m32 ? ~c32 : {16'h0, ~c16};
  endfunction

  task automatic send_frame(logic [7:0] d[$], bit m32, bit flip);
    logic [31:0] f;
    cfg_crc32 = m32;
    exp_q.push_back(8'h7E); tag_q.push_back("R2");
    foreach (d[k]) push_enc(d[k], "");
    f = ref_fcs(d, m32);
    for (int k = 0; k < (m32 ? 4 : 2); k++) push_enc(f[8*k +: 8], m32 ? "R9" : "R8");
    exp_q.push_back(8'h7E); tag_q.push_back("R11");
    foreach (d[k]) begin
      in_valid = 1; in_data = d[k]; in_last = (k == d.size() - 1);
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 0; in_last = 0;
      if (flip && k == 0) cfg_crc32 = ~m32;
    end
    while (exp_q.size() != 0) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    #1;
    out_ready = bp_on ? (($urandom % 4) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected byte", {24'h0, out_data}, 32'hFFFF_FFFF);
      end else begin
        string t;
        t = tag_q.pop_front();
        check(t, {24'h0, out_data}, {24'h0, exp_q.pop_front()});
        if (t == "R6") check("R6 in_ready in pair", {31'h0, in_ready}, 32'h0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] d[$];
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {31'h0, out_valid}, 0);
    check("R1 in_ready in reset", {31'h0, in_ready}, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check("R1 out_valid idle", {31'h0, out_valid}, 0);
    check("R1 in_ready idle", {31'h0, in_ready}, 0);

    cfg_accm = 32'hFFFF_FFFF;
    d = '{8'h01, 8'h7E, 8'h7D, 8'h41, 8'h1F, 8'h20, 8'h5E};
    send_frame(d, 0, 0);

    cfg_accm = 32'h0;
    d = '{8'h00, 8'h11, 8'h13, 8'h7E, 8'h99};
    send_frame(d, 1, 1);

    cfg_accm = 32'h000A_0000;
    cfg_extra = {8'h80, 8'h41, 8'hFF, 8'h5E};
    cfg_extra_en = 4'b1011;
    d = '{8'h5E, 8'hFF, 8'h41, 8'h80, 8'h11, 8'h13, 8'h12, 8'h7D};
    send_frame(d, 0, 0);

    d = '{8'h33};
    send_frame(d, 1, 0);

    bp_on = 1;
    for (int n = 0; n < 40; n++) begin
      cfg_accm = $urandom;
      cfg_extra = $urandom;
      cfg_extra_en = 4'($urandom);
      d.delete();
      for (int k = 0; k < 1 + ($urandom % 12); k++) d.push_back(8'($urandom));
      send_frame(d, 1'($urandom), 1'($urandom));
    end
    bp_on = 0;

    repeat (3) @(negedge clk);
    check("R11 idle after close", {31'h0, out_valid}, 0);
    check("R12 no leftover bytes", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule